// File: doc/BRIEF.md
# Stride Value Predictor with Speculative Chaining

The block guesses the 32-bit result of an instruction before it executes. It keeps, for each tracked instruction address, the last committed result and the difference between the last two committed results. The guess is the sum of the two. Entries sit in a set-associative table. The set comes from the low bits of the address, and the remaining bits are stored as the tag. Each entry carries a 3-bit confidence counter. The counter climbs when the same difference repeats and drops to zero as soon as the difference changes.

Several instances of one instruction can be in flight at the same time. A committed base value would be stale for every instance after the first. A small speculative window therefore keeps, for each address with instances in flight, the most recent guessed value and a flag saying whether that guess was trustworthy. A lookup that finds a window entry uses the window value as its base in place of the committed one. The sum produced in one cycle is written back to the window, so a lookup in the next cycle chains on it. Each commit for an address lowers that address's in-flight count, and the window entry is released when the count reaches zero. A squash empties the window.

The fetch stage drives one lookup per cycle. The commit stage drives one update per cycle. The prediction appears one cycle after the lookup.

Top module: `stride_vpred`

## Requirements
- R1: A lookup whose address hits the table gives, on the next cycle, `pred_valid_o`=1 and `pred_value_o` = base + stored stride. The base is the window value if the address has a window entry, and the committed last value otherwise. A lookup that misses gives `pred_valid_o`=0 on the next cycle.
- R2: The set index is `pc[$clog2(SETS)-1:0]` and the remaining bits form the tag. `WAYS` different addresses that share a set can all be present together.
- R3: A commit that hits sets the stride to (actual result − committed last value), then sets the last value to the actual result.
- R4: A commit that hits increments confidence, saturating at 7, when the new stride equals the stored one and the probability gate is open. With `PROB_LOG2`=0 the gate is always open. When the new stride differs, confidence goes to 0.
- R5: `pred_usable_o` is 1 only when all of these hold: the entry's confidence is 7; the address either has no window entry or has a window entry flagged trustworthy; and the address either has a window entry or a free window slot exists. `pred_usable_o` is never 1 without `pred_valid_o`.
- R6: Lookups of the same address in successive cycles, with no commits in between, predict last+s, last+2s, last+3s, and so on, where s is the stored stride.
- R7: Each lookup that hits the table increments the in-flight count of its window entry, allocating the entry if none exists. Each commit of that address decrements the count. At zero the entry is released, and the next lookup bases its prediction on the committed last value.
- R8: A commit that misses allocates a way in its set. An invalid way is taken first; otherwise the least recently committed way is replaced. The new entry has the result as its last value, stride 0 and confidence 0.
- R9: A squash empties the window. The next lookup bases its prediction on the committed last value.
- R10: While reset is active and after reset, `pred_valid_o` and `pred_usable_o` are 0 and the table is empty.
- R11: When the window is full and a lookup hits the table for an address that has no window entry, the prediction value still follows R1, `pred_usable_o` is 0, and no window entry is created.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Fetch-time lookup request |
| lk_pc_i | input | 32 | Lookup address |
| cm_valid_i | input | 1 | Commit-time update request |
| cm_pc_i | input | 32 | Committed instruction address |
| cm_value_i | input | 32 | Actual committed result |
| squash_i | input | 1 | Flush the speculative window |
| pred_valid_o | output | 1 | Prediction present (registered) |
| pred_usable_o | output | 1 | Prediction is high confidence |
| pred_value_o | output | 32 | Predicted result |

## Verification
The assertions assume that no address has more than 2^CNT_W−1 instances in flight. The stimulus respects this by skipping any lookup whose modelled count has reached 6. The assertions also assume that a squash never arrives in the same cycle as a lookup, and the bench never issues the two together. A behavioural model built from queues and associative arrays predicts every output on every cycle. Directed phases cover chaining, release, squash, stride change, LRU eviction and a full window. A random phase mixes three addresses that collide in one set with two addresses in other sets. The bench uses `PROB_LOG2`=0, which makes confidence growth deterministic.

// File: rtl/svp_pkg.sv
package svp_pkg;
  localparam int unsigned PC_W   = 32;
  localparam int unsigned VAL_W  = 32;
  localparam int unsigned CONF_W = 3;

  typedef logic [PC_W-1:0]   pc_t;
  typedef logic [VAL_W-1:0]  val_t;
  typedef logic [CONF_W-1:0] conf_t;

  localparam conf_t CONF_MAX = '1;

  typedef struct packed {
    logic  hit;
    val_t  last;
    val_t  stride;
    conf_t conf;
  } tbl_rd_t;
endpackage

// File: rtl/svp_gate.sv
module svp_gate #(
  parameter int unsigned PROB_LOG2 = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic adv_o
);
  localparam logic [15:0] MASK = 16'((32'd1 << PROB_LOG2) - 32'd1);

  logic [15:0] lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= 16'hACE1;
    else         lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  // gate open 1 in 2^PROB_LOG2 cycles; always open when PROB_LOG2 = 0
  assign adv_o = (lfsr_q & MASK) == 16'h0;
endmodule

// File: rtl/svp_table.sv
module svp_table import svp_pkg::*; #(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  pc_t     rd_pc_i,
  output tbl_rd_t rd_o,
  input  logic    wr_valid_i,
  input  pc_t     wr_pc_i,
  input  val_t    wr_value_i,
  input  logic    adv_ok_i
);
  localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int unsigned TAG_W = PC_W - IDX_W;
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [IDX_W-1:0] set_t;
  typedef logic [WAY_W-1:0] way_t;

  logic v_q      [SETS][WAYS];
  tag_t tag_q    [SETS][WAYS];
  val_t last_q   [SETS][WAYS];
  val_t stride_q [SETS][WAYS];
  conf_t conf_q  [SETS][WAYS];
  way_t age_q    [SETS][WAYS];

  set_t rd_set, wr_set;
  tag_t rd_tag, wr_tag;
  assign rd_set = rd_pc_i[IDX_W-1:0];
  assign rd_tag = rd_pc_i[PC_W-1:IDX_W];
  assign wr_set = wr_pc_i[IDX_W-1:0];
  assign wr_tag = wr_pc_i[PC_W-1:IDX_W];

  always_comb begin
    rd_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (v_q[rd_set][w] && tag_q[rd_set][w] == rd_tag) begin
        rd_o.hit    = 1'b1;
        rd_o.last   = last_q[rd_set][w];
        rd_o.stride = stride_q[rd_set][w];
        rd_o.conf   = conf_q[rd_set][w];
      end
    end
  end

  logic  wr_hit, free_found;
  way_t  hit_way, victim, tgt;
  val_t  new_stride;
  conf_t conf_inc, conf_nxt;

  always_comb begin
    wr_hit     = 1'b0;
    hit_way    = '0;
    free_found = 1'b0;
    victim     = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (v_q[wr_set][w] && tag_q[wr_set][w] == wr_tag) begin
        wr_hit  = 1'b1;
        hit_way = way_t'(w);
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!free_found && !v_q[wr_set][w]) begin
        free_found = 1'b1;
        victim     = way_t'(w);
      end
    end
    if (!free_found) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[wr_set][w] == way_t'(WAYS - 1)) victim = way_t'(w);
    end
    tgt        = wr_hit ? hit_way : victim;
    new_stride = wr_value_i - last_q[wr_set][hit_way];
    conf_inc   = (conf_q[wr_set][hit_way] == CONF_MAX) ? CONF_MAX : conf_q[wr_set][hit_way] + conf_t'(1);
    if (!wr_hit)                                   conf_nxt = '0;
    else if (new_stride != stride_q[wr_set][hit_way]) conf_nxt = '0;
    else if (adv_ok_i)                             conf_nxt = conf_inc;
    else                                           conf_nxt = conf_q[wr_set][hit_way];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          v_q[s][w]      <= 1'b0;
          tag_q[s][w]    <= '0;
          last_q[s][w]   <= '0;
          stride_q[s][w] <= '0;
          conf_q[s][w]   <= '0;
          age_q[s][w]    <= way_t'(w);
        end
      end
    end else if (wr_valid_i) begin
      v_q[wr_set][tgt]      <= 1'b1;
      tag_q[wr_set][tgt]    <= wr_tag;
      last_q[wr_set][tgt]   <= wr_value_i;
      stride_q[wr_set][tgt] <= wr_hit ? new_stride : '0;
      conf_q[wr_set][tgt]   <= conf_nxt;
      for (int w = 0; w < WAYS; w++) begin
        if (way_t'(w) == tgt)                           age_q[wr_set][w] <= '0;
        else if (age_q[wr_set][w] < age_q[wr_set][tgt]) age_q[wr_set][w] <= age_q[wr_set][w] + way_t'(1);
      end
    end
  end

  // checker state: where the last write landed and what it must have left
  logic chk_zero_q, chk_alloc_q;
  set_t chk_set_q;
  way_t chk_way_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_zero_q  <= 1'b0;
      chk_alloc_q <= 1'b0;
      chk_set_q   <= '0;
      chk_way_q   <= '0;
    end else begin
      chk_zero_q  <= wr_valid_i && wr_hit && (new_stride != stride_q[wr_set][hit_way]);
      chk_alloc_q <= wr_valid_i && !wr_hit;
      chk_set_q   <= wr_set;
      chk_way_q   <= tgt;
    end
  end

  // R4
  conf_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_zero_q |-> conf_q[chk_set_q][chk_way_q] == '0);
  // R8
  alloc_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_alloc_q |-> (v_q[chk_set_q][chk_way_q] && stride_q[chk_set_q][chk_way_q] == '0
                     && conf_q[chk_set_q][chk_way_q] == '0));
endmodule

// File: rtl/svp_window.sv
module svp_window import svp_pkg::*; #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic squash_i,
  input  pc_t  lk_pc_i,
  output logic hit_o,
  output val_t val_o,
  output logic hc_o,
  output logic room_o,
  input  logic wr_i,
  input  val_t wr_val_i,
  input  logic wr_hc_i,
  input  logic cm_valid_i,
  input  pc_t  cm_pc_i
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [IDX_W-1:0] idx_t;

  logic [DEPTH-1:0] v_q, hc_q, inc_v, dec_v;
  pc_t  pc_q  [DEPTH];
  val_t val_q [DEPTH];
  cnt_t cnt_q [DEPTH];
  cnt_t cnt_d [DEPTH];
  idx_t lk_idx, cm_idx, free_idx;
  logic cm_hit;

  always_comb begin
    hit_o = 1'b0; lk_idx = '0;
    cm_hit = 1'b0; cm_idx = '0;
    room_o = 1'b0; free_idx = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (v_q[e] && pc_q[e] == lk_pc_i) begin hit_o = 1'b1; lk_idx = idx_t'(e); end
      if (v_q[e] && pc_q[e] == cm_pc_i) begin cm_hit = 1'b1; cm_idx = idx_t'(e); end
      if (!v_q[e] && !room_o)           begin room_o = 1'b1; free_idx = idx_t'(e); end
    end
    val_o = val_q[lk_idx];
    hc_o  = hc_q[lk_idx];
    for (int e = 0; e < DEPTH; e++) begin
      inc_v[e] = wr_i && (hit_o ? (lk_idx == idx_t'(e)) : (free_idx == idx_t'(e)));
      dec_v[e] = cm_valid_i && cm_hit && (cm_idx == idx_t'(e));
      cnt_d[e] = (v_q[e] ? cnt_q[e] : cnt_t'(0)) + cnt_t'(inc_v[e]) - cnt_t'(dec_v[e]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q  <= '0;
      hc_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        pc_q[e] <= '0; val_q[e] <= '0; cnt_q[e] <= '0;
      end
    end else if (squash_i) begin
      v_q <= '0;
      for (int e = 0; e < DEPTH; e++) cnt_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        v_q[e]   <= cnt_d[e] != '0;
        cnt_q[e] <= cnt_d[e];
        if (inc_v[e]) begin
          pc_q[e]  <= lk_pc_i;
          val_q[e] <= wr_val_i;
          hc_q[e]  <= wr_hc_i;
        end
      end
    end
  end

  // R9
  squash_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> v_q == '0);
  // R7
  cnt_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_o && (&cnt_q[lk_idx])) |-> dec_v[lk_idx]);
endmodule

// File: rtl/stride_vpred.sv
module stride_vpred import svp_pkg::*; #(
  parameter int unsigned SETS      = 16,
  parameter int unsigned WAYS      = 2,
  parameter int unsigned WIN_DEPTH = 4,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned PROB_LOG2 = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lk_valid_i,
  input  logic [31:0] lk_pc_i,
  input  logic        cm_valid_i,
  input  logic [31:0] cm_pc_i,
  input  logic [31:0] cm_value_i,
  input  logic        squash_i,
  output logic        pred_valid_o,
  output logic        pred_usable_o,
  output logic [31:0] pred_value_o
);
  tbl_rd_t tbl_rd;
  logic    adv_ok, win_hit, win_hc, win_room, win_wr, room, usable;
  val_t    win_val, base, sum;

  svp_gate #(.PROB_LOG2(PROB_LOG2)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_o(adv_ok)
  );

  svp_table #(.SETS(SETS), .WAYS(WAYS)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_pc_i(lk_pc_i), .rd_o(tbl_rd),
    .wr_valid_i(cm_valid_i), .wr_pc_i(cm_pc_i), .wr_value_i(cm_value_i),
    .adv_ok_i(adv_ok)
  );

  svp_window #(.DEPTH(WIN_DEPTH), .CNT_W(CNT_W)) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .squash_i(squash_i),
    .lk_pc_i(lk_pc_i), .hit_o(win_hit), .val_o(win_val), .hc_o(win_hc), .room_o(win_room),
    .wr_i(win_wr), .wr_val_i(sum), .wr_hc_i(usable),
    .cm_valid_i(cm_valid_i), .cm_pc_i(cm_pc_i)
  );

  // window value overrides the committed base; sum chains back next cycle
  assign base   = win_hit ? win_val : tbl_rd.last;
  assign sum    = base + tbl_rd.stride;
  assign room   = win_hit || win_room;
  assign usable = (tbl_rd.conf == CONF_MAX) && (!win_hit || win_hc) && room;
  assign win_wr = lk_valid_i && tbl_rd.hit && room;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o  <= 1'b0;
      pred_usable_o <= 1'b0;
      pred_value_o  <= '0;
    end else begin
      pred_valid_o  <= lk_valid_i && tbl_rd.hit;
      pred_usable_o <= lk_valid_i && tbl_rd.hit && usable;
      if (lk_valid_i && tbl_rd.hit) pred_value_o <= sum;
    end
  end

  // R5
  usable_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_usable_o |-> pred_valid_o);
  // R5
  low_conf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && tbl_rd.hit && tbl_rd.conf != CONF_MAX) |=> !pred_usable_o);
  // R1
  pred_after_lookup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> $past(lk_valid_i));
endmodule

// File: tb/sim_stride_vpred.sv
module sim_stride_vpred;
  localparam int SETS = 16;
  localparam int WAYS = 2;
  localparam int WIN  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, cm_valid = 1'b0, squash = 1'b0;
  logic [31:0] lk_pc = '0, cm_pc = '0, cm_value = '0;
  logic        pred_valid, pred_usable;
  logic [31:0] pred_value;

  always #4 clk = ~clk;

  stride_vpred #(.SETS(SETS), .WAYS(WAYS), .WIN_DEPTH(WIN), .CNT_W(3), .PROB_LOG2(0)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_pc_i(lk_pc),
    .cm_valid_i(cm_valid), .cm_pc_i(cm_pc), .cm_value_i(cm_value),
    .squash_i(squash),
    .pred_valid_o(pred_valid), .pred_usable_o(pred_usable), .pred_value_o(pred_value)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_last   [logic [31:0]];
  logic [31:0] m_stride [logic [31:0]];
  int          m_conf   [logic [31:0]];
  logic [31:0] setq     [SETS][$];
  logic [31:0] w_val    [logic [31:0]];
  bit          w_hc     [logic [31:0]];
  int          w_cnt    [logic [31:0]];
  bit          exp_v, exp_u;
  logic [31:0] exp_val;

  function automatic int find_way(logic [31:0] pc);
    foreach (setq[pc % SETS][i]) if (setq[pc % SETS][i] == pc) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(bit lk, logic [31:0] lpc, bit cm, logic [31:0] cpc,
                            logic [31:0] cval, bit sq);
    bit cm_in_win = w_cnt.exists(cpc);
    bit wr = 0;
    exp_v = 0; exp_u = 0;
    if (lk && find_way(lpc) >= 0) begin
      bit we = w_cnt.exists(lpc);
      bit rm = we || (w_cnt.num() < WIN);
      logic [31:0] b = we ? w_val[lpc] : m_last[lpc];
      exp_v   = 1;
      exp_val = b + m_stride[lpc];
      exp_u   = (m_conf[lpc] == 7) && (!we || w_hc[lpc]) && rm;
      wr      = rm;
    end
    if (sq) begin
      w_val.delete(); w_hc.delete(); w_cnt.delete();
    end else begin
      if (wr) begin
        w_val[lpc] = exp_val;
        w_hc[lpc]  = exp_u;
        w_cnt[lpc] = w_cnt.exists(lpc) ? w_cnt[lpc] + 1 : 1;
      end
      if (cm && cm_in_win) begin
        w_cnt[cpc] = w_cnt[cpc] - 1;
        if (w_cnt[cpc] == 0) begin
          w_cnt.delete(cpc); w_val.delete(cpc); w_hc.delete(cpc);
        end
      end
    end
    if (cm) begin
      int wy = find_way(cpc);
      int s  = cpc % SETS;
      if (wy >= 0) begin
        logic [31:0] ns = cval - m_last[cpc];
        if (ns == m_stride[cpc]) m_conf[cpc] = (m_conf[cpc] == 7) ? 7 : m_conf[cpc] + 1;
        else                     m_conf[cpc] = 0;
        m_stride[cpc] = ns;
        m_last[cpc]   = cval;
        setq[s].delete(wy);
        setq[s].push_front(cpc);
      end else begin
        if (setq[s].size() == WAYS) begin
          logic [31:0] ev = setq[s].pop_back();
          m_last.delete(ev); m_stride.delete(ev); m_conf.delete(ev);
        end
        setq[s].push_front(cpc);
        m_last[cpc] = cval; m_stride[cpc] = '0; m_conf[cpc] = 0;
      end
    end
  endtask

  task automatic cyc(bit lk, logic [31:0] lpc, bit cm, logic [31:0] cpc,
                     logic [31:0] cval, bit sq, string tag);
    lk_valid = lk; lk_pc = lpc; cm_valid = cm; cm_pc = cpc; cm_value = cval; squash = sq;
    @(posedge clk);
    model_step(lk, lpc, cm, cpc, cval, sq);
    @(negedge clk);
    chk(pred_valid == exp_v, tag, "pred_valid", 32'(pred_valid), 32'(exp_v));
    chk(pred_usable == exp_u, tag, "pred_usable", 32'(pred_usable), 32'(exp_u));
    if (exp_v) chk(pred_value == exp_val, tag, "pred_value", pred_value, exp_val);
  endtask

  task automatic look(logic [31:0] pc, string tag);  cyc(1, pc, 0, 0, 0, 0, tag); endtask
  task automatic commit(logic [31:0] pc, logic [31:0] v, string tag); cyc(0, 0, 1, pc, v, 0, tag); endtask
  task automatic flush(string tag); cyc(0, 0, 0, 0, 0, 1, tag); endtask

  task automatic train(logic [31:0] pc, logic [31:0] v0, logic [31:0] s);
    for (int i = 0; i < 9; i++) commit(pc, v0 + 32'(i) * s, "R3");
  endtask

  localparam logic [31:0] PA = 32'h100, PB = 32'h200, PC = 32'h300;
  localparam logic [31:0] PD = 32'h104, PE = 32'h108, PF = 32'h10C;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pred_valid == 0 && pred_usable == 0, "R10", "reset outputs", 32'(pred_valid), 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, "R10");
    look(PA, "R10");                       // empty table: no prediction

    train(PA, 10, 3);                      // last 34, stride 3, conf 7
    look(PA, "R1");
    chk(pred_value == 37 && pred_usable, "R5", "first usable", pred_value, 37);
    look(PA, "R6");
    chk(pred_value == 40, "R6", "chain 2", pred_value, 40);
    look(PA, "R6");
    chk(pred_value == 43, "R6", "chain 3", pred_value, 43);
    commit(PA, 37, "R7"); commit(PA, 40, "R7"); commit(PA, 43, "R7");
    look(PA, "R7");
    chk(pred_value == 46, "R7", "after release", pred_value, 46);
    commit(PA, 46, "R7");

    look(PA, "R9"); look(PA, "R9");
    flush("R9");
    look(PA, "R9");
    chk(pred_value == 49, "R9", "after squash", pred_value, 49);
    flush("R9");
    commit(PA, 49, "R3"); commit(PA, 52, "R3");

    commit(PA, 100, "R4");                 // stride 48, conf reset
    look(PA, "R4");
    chk(!pred_usable && pred_value == 148, "R4", "stride change", pred_value, 148);
    flush("R4");

    commit(PB, 5, "R8");
    commit(PA, 103, "R2");
    commit(PC, 7, "R8");                   // evicts PB
    look(PB, "R8");
    chk(!pred_valid, "R8", "LRU victim gone", 32'(pred_valid), 0);
    look(PA, "R2");
    look(PC, "R8");
    chk(pred_valid && pred_value == 7 && !pred_usable, "R8", "fresh entry", pred_value, 7);
    flush("R8");

    train(PD, 1000, 4); train(PE, 2000, 8); train(PF, 3000, 16);
    look(PD, "R11"); look(PE, "R11"); look(PF, "R11");
    chk(!pred_usable && pred_value == 3000 + 16 * 9, "R11", "window full", pred_value, 3144);
    look(PF, "R11");
    flush("R11");

    begin
      logic [31:0] pcs [5] = '{PA, PB, PC, 32'h114, 32'h128};
      logic [31:0] nv [5]  = '{500, 600, 700, 800, 900};
      logic [31:0] st [5]  = '{3, 5, 0, 7, 1};
      for (int n = 0; n < 600; n++) begin
        bit lk = ($urandom % 2) == 0;
        bit cm = ($urandom % 2) == 0;
        bit sq = !lk && ($urandom % 30) == 0;
        int li = $urandom % 5;
        int ci = $urandom % 5;
        logic [31:0] v = nv[ci];
        if (lk && w_cnt.exists(pcs[li]) && w_cnt[pcs[li]] >= 6) lk = 0;
        if (cm) begin
          nv[ci] = nv[ci] + st[ci];
          if (($urandom % 7) == 0) nv[ci] = $urandom;
        end
        cyc(lk, pcs[li], cm, pcs[ci], v, sq, "R1");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule